// File: doc/BRIEF.md
# Pin Interrupt Port Controller

This block watches a small group of input pins (eight by default) and combines them into one interrupt request. Each pin has an enable bit and a polarity bit. The polarity bit chooses which level counts as asserted. A shared mode bit chooses between edge-only detection and detection of either an edge or a held level. Each pin passes through a synchronizer before detection. Any valid event on an enabled pin sets one shared flag. The flag drives the interrupt output while the interrupt enable is set.

Software reaches three registers through a simple write strobe and an address bus. Reads are combinational. The polarity bits also go straight out as pull-direction selects for the pad logic. In level mode the acknowledge bit clears the flag only when every enabled pin is back at its idle level. In edge mode an acknowledge always clears the flag. A new event arriving in the same cycle as an acknowledge wins over the acknowledge.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every register reads 0, the flag is clear, `irq` is 0 and every `pull_dn_sel` bit is 0.
- R2: On an enabled pin with polarity 1, a rising edge sets the flag; with polarity 0, a falling edge sets it. The flag reads 1 on the third rising clock edge after the pin changes, and not before.
- R3: With the mode bit set, a pin that is enabled and held at its asserted level sets the flag, and keeps setting it for as long as it is held.
- R4: A pin whose enable bit is 0 never sets the flag and does not block an acknowledge.
- R5: `irq` is 1 exactly when the flag is 1 and the interrupt-enable bit is 1.
- R6: In level mode (mode bit 1), an acknowledge write leaves the flag set while any enabled pin is asserted, and clears it once all enabled pins are deasserted.
- R7: In edge-only mode (mode bit 0), an acknowledge write clears the flag whatever the pin levels are.
- R8: When an edge is detected in the same cycle as an acknowledge, the flag stays set.
- R9: The register map is as follows. Address 0 is control: bit 0 is the interrupt enable, bit 1 is the mode, bit 2 is the acknowledge (write-only, reads 0) and bit 3 is the flag (read-only; writes to it are ignored). Address 1 holds the pin enables and address 2 the polarities. Address 3 reads 0.
- R10: `pull_dn_sel[i]` equals polarity bit i, where 1 selects pull-down and 0 selects pull-up.
- R11: A false flag raised while a pin is being enabled, with the interrupt enable still 0, is cleared by one acknowledge written once the pin has gone idle. Setting the interrupt enable afterwards raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| pins_in | input | NPINS | Asynchronous pin inputs |
| pull_dn_sel | output | NPINS | Per-pin pull select: 1 = pull-down, 0 = pull-up |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences drive single pins with falling and rising transitions under both polarities. This shows that detection follows the polarity bit and not a fixed edge. Held-low and held-high levels with the mode bit on and off separate level capture from edge capture. They also show how the acknowledge is gated in each mode. Toggling a disabled pin, and timing an edge to land on the acknowledge cycle, isolate the enable mask and the set-over-clear priority. Random epochs then change the mode, the masks and the pin patterns (several pins changing at once), and compare the flag and `irq` against a model of the requirements.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
   // register addresses
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_EN   = 1;
   localparam int unsigned REG_POL  = 2;
   // control register bit positions
   localparam int unsigned CTL_IE   = 0;
   localparam int unsigned CTL_MODE = 1;
   localparam int unsigned CTL_ACK  = 2;
   localparam int unsigned CTL_FLAG = 3;
   localparam int unsigned CTL_BITS = 4;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pinirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d_async;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_s,
   input  logic [NPINS-1:0] pin_en,
   input  logic [NPINS-1:0] pin_pol,
   output logic [NPINS-1:0] edge_vec,
   output logic [NPINS-1:0] active_vec
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_s;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic now_asserted;
      logic was_asserted;
      assign now_asserted  = pin_pol[i] ? pin_s[i]  : ~pin_s[i];
      assign was_asserted  = pin_pol[i] ? prev_q[i] : ~prev_q[i];
      assign active_vec[i] = pin_en[i] & now_asserted;
      assign edge_vec[i]   = pin_en[i] & now_asserted & ~was_asserted;
   end
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
   import pinirq_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pins_in,
   output logic [NPINS-1:0]  pull_dn_sel,
   output logic              irq
);
   localparam int unsigned NREGS = 3;

   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("pinirq_ctrl: NPINS must be 1..DATA_W");
   end
   if (DATA_W < CTL_BITS) begin : g_bad_dw
      $error("pinirq_ctrl: DATA_W too narrow for control register");
   end
   if ((1 << ADDR_W) < NREGS) begin : g_bad_aw
      $error("pinirq_ctrl: ADDR_W too narrow for register map");
   end

   logic              ie_q, mode_q, flag_q;
   logic [NPINS-1:0]  en_q, pol_q;
   logic [NPINS-1:0]  pin_s, edge_vec, active_vec;
   logic              wr_ctrl, wr_en, wr_pol, ack_wr;
   logic              set_evt, clr_ok;

   pinirq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_in),
      .q_sync  (pin_s)
   );

   pinirq_detect #(.NPINS(NPINS)) u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (pin_s),
      .pin_en     (en_q),
      .pin_pol    (pol_q),
      .edge_vec   (edge_vec),
      .active_vec (active_vec)
   );

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign wr_en   = bus_wr && (bus_addr == ADDR_W'(REG_EN));
   assign wr_pol  = bus_wr && (bus_addr == ADDR_W'(REG_POL));
   assign ack_wr  = wr_ctrl && bus_wdata[CTL_ACK];

   assign set_evt = (|edge_vec) || (mode_q && (|active_vec));
   assign clr_ok  = ack_wr && (!mode_q || !(|active_vec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         mode_q <= 1'b0;
         en_q   <= '0;
         pol_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ie_q   <= bus_wdata[CTL_IE];
            mode_q <= bus_wdata[CTL_MODE];
         end
         if (wr_en)  en_q  <= bus_wdata[NPINS-1:0];
         if (wr_pol) pol_q <= bus_wdata[NPINS-1:0];
         if (set_evt)     flag_q <= 1'b1;
         else if (clr_ok) flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_CTRL): begin
            bus_rdata[CTL_IE]   = ie_q;
            bus_rdata[CTL_MODE] = mode_q;
            bus_rdata[CTL_FLAG] = flag_q;
         end
         ADDR_W'(REG_EN):  bus_rdata[NPINS-1:0] = en_q;
         ADDR_W'(REG_POL): bus_rdata[NPINS-1:0] = pol_q;
         default: bus_rdata = '0;
      endcase
   end

   assign pull_dn_sel = pol_q;
   assign irq         = flag_q & ie_q;
endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk #(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flag_q,
   input logic              mode_q,
   input logic              ie_q,
   input logic              ack_wr,
   input logic              irq,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  edge_vec,
   input logic [NPINS-1:0]  active_vec
);
   AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_vec) |=> flag_q); // R2

   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && (|active_vec)) |=> flag_q); // R3

   AST_ACK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && mode_q && (|active_vec)) |=> flag_q); // R6

   AST_ACK_EDGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !mode_q && !(|edge_vec)) |=> !flag_q); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && (|edge_vec)) |=> flag_q); // R8

   AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_wr && !(|edge_vec) && !(mode_q && (|active_vec))) |=> $stable(flag_q)); // R9

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_q && ie_q)); // R5

   AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == '0) |-> !bus_rdata[2]); // R9
endmodule

bind pinirq_ctrl pinirq_chk #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_q     (flag_q),
   .mode_q     (mode_q),
   .ie_q       (ie_q),
   .ack_wr     (ack_wr),
   .irq        (irq),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .edge_vec   (edge_vec),
   .active_vec (active_vec)
);

// File: tb/tb_pinirq_ctrl.sv
module tb_pinirq_ctrl;
   localparam int NP = 8;
   localparam int DW = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NP-1:0] pins_in = 8'hFF;
   logic [NP-1:0] pull_dn_sel;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pinirq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
      .pull_dn_sel(pull_dn_sel), .irq(irq)
   );

   // bench model state
   logic          m_ie, m_mode, m_flag;
   logic [NP-1:0] m_en, m_pol;

   function automatic logic [NP-1:0] asrt(logic [NP-1:0] p, logic [NP-1:0] pol);
      return ~(p ^ pol);
   endfunction

   function automatic logic any_active(logic [NP-1:0] p);
      return |(m_en & asrt(p, m_pol));
   endfunction

   function automatic logic any_edge(logic [NP-1:0] o, logic [NP-1:0] n);
      return |(m_en & asrt(n, m_pol) & ~asrt(o, m_pol));
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, logic [DW-1:0] d);
      bus_addr  = AW'(a);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(int a, output logic [DW-1:0] d);
      bus_addr = AW'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic chk_flag(string req, logic exp);
      logic [DW-1:0] d;
      rd(0, d);
      check(req, 32'(d[3]), 32'(exp));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      logic [NP-1:0] old;
      void'($urandom(32'h5EED_1234));
      cyc(3);
      rst_n = 1'b1;
      cyc(4);
      // R1 reset state
      for (int a = 0; a < 3; a++) begin
         rd(a, d);
         check("R1 reg", 32'(d), 32'h0);
      end
      check("R1 irq", 32'(irq), 0);
      check("R1 pull", 32'(pull_dn_sel), 0);

      // R9 flag bit write ignored, ack reads 0, address 3 reads 0
      wr(0, 8'h08);
      rd(0, d); check("R9 flag write ignored", 32'(d), 0);
      wr(0, 8'h04);
      rd(0, d); check("R9 ack reads 0", 32'(d), 0);
      rd(3, d); check("R9 unused addr", 32'(d), 0);

      // R11 init sequence with a false flag
      wr(0, 8'h02);                 // level mode, ie=0
      pins_in = 8'hFE; cyc(4);      // pin0 low before enabling
      wr(1, 8'h01);                 // enable pin0, polarity 0
      cyc(3);
      chk_flag("R11 false flag raised", 1'b1);
      check("R11 no irq while masked", 32'(irq), 0);
      pins_in = 8'hFF; cyc(4);
      wr(0, 8'h06);                 // ack
      chk_flag("R11 ack clears", 1'b0);
      wr(0, 8'h03);                 // set ie
      cyc(3);
      check("R11 no irq after enable", 32'(irq), 0);

      // R2 falling edge (pol 0), timing, R5 irq
      wr(0, 8'h01);                 // edge mode, ie=1
      cyc(2);
      pins_in[0] = 1'b0;
      cyc(2);
      chk_flag("R2 not before third edge", 1'b0);
      cyc(1);
      chk_flag("R2 falling edge sets", 1'b1);
      check("R5 irq with ie", 32'(irq), 1);
      // R7 edge-mode ack clears while pin held
      wr(0, 8'h05);
      chk_flag("R7 ack clears in edge mode", 1'b0);
      check("R5 irq low after clear", 32'(irq), 0);

      // R2 rising edge with polarity 1
      wr(2, 8'h02); wr(1, 8'h03);
      pins_in[1] = 1'b0; cyc(4);
      chk_flag("R2 falling ignored with pol 1", 1'b0);
      pins_in[1] = 1'b1; cyc(4);
      chk_flag("R2 rising edge sets", 1'b1);
      wr(0, 8'h05);
      chk_flag("R7 ack clears", 1'b0);

      // R4 disabled pin ignored, level mode
      pins_in = 8'hFD; cyc(4);      // pin0 high, pin1 low: both idle
      wr(0, 8'h04);
      wr(0, 8'h02);
      cyc(3);
      chk_flag("R4 idle level mode", 1'b0);
      pins_in[2] = 1'b0; cyc(4);
      pins_in[2] = 1'b1; cyc(4);
      pins_in[2] = 1'b0; cyc(4);
      chk_flag("R4 disabled pin ignored", 1'b0);
      wr(0, 8'h06);
      chk_flag("R4 ack not blocked by disabled pin", 1'b0);

      // R3 level sets, R6 ack blocked then clears
      pins_in[0] = 1'b0; cyc(4);
      chk_flag("R3 level sets", 1'b1);
      wr(0, 8'h06);
      chk_flag("R6 ack blocked while asserted", 1'b1);
      pins_in[0] = 1'b1; cyc(4);
      chk_flag("R3 flag latched after release", 1'b1);
      wr(0, 8'h06);
      chk_flag("R6 ack clears when idle", 1'b0);

      // R8 set wins over ack
      wr(0, 8'h01);
      pins_in[0] = 1'b0; cyc(4);
      pins_in[0] = 1'b1; cyc(4);
      chk_flag("R8 setup flag", 1'b1);
      pins_in[0] = 1'b0;
      cyc(2);
      wr(0, 8'h05);
      chk_flag("R8 edge beats ack", 1'b1);
      wr(0, 8'h05);
      chk_flag("R8 later ack clears", 1'b0);

      // R10 pull select follows polarity
      wr(2, 8'hA5);
      check("R10 pull select", 32'(pull_dn_sel), 32'hA5);
      rd(2, d); check("R9 polarity readback", 32'(d), 32'hA5);
      wr(1, 8'h3C);
      rd(1, d); check("R9 enable readback", 32'(d), 32'h3C);

      // random epochs
      for (int ep = 0; ep < 40; ep++) begin
         m_ie   = 1'($urandom_range(0, 1));
         m_mode = 1'($urandom_range(0, 1));
         m_en   = NP'($urandom);
         m_pol  = NP'($urandom);
         wr(0, {6'b0, m_mode, m_ie});
         wr(1, m_en);
         wr(2, m_pol);
         check("R10 pull random", 32'(pull_dn_sel), 32'(m_pol));
         cyc(4);
         wr(0, {5'b0, 1'b1, m_mode, m_ie});
         m_flag = m_mode & any_active(pins_in);
         chk_flag(m_mode ? "R6 ack after config" : "R7 ack after config", m_flag);
         for (int st = 0; st < 10; st++) begin
            old = pins_in;
            pins_in = pins_in ^ NP'($urandom & $urandom);
            cyc(4);
            if (any_edge(old, pins_in)) m_flag = 1'b1;
            if (m_mode && any_active(pins_in)) m_flag = 1'b1;
            chk_flag(m_mode ? "R3 random level/edge" : "R2 random edge", m_flag);
            check("R5 random irq", 32'(irq), 32'(m_flag & m_ie));
            if ($urandom_range(0, 2) == 0) begin
               wr(0, {5'b0, 1'b1, m_mode, m_ie});
               m_flag = m_mode & any_active(pins_in);
               chk_flag(m_mode ? "R6 random ack" : "R7 random ack", m_flag);
            end
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule